// File: doc/BRIEF.md
# Boot Mode Pad Capture Filter

This block records the level of a small group of boot-mode pads while the external reset is held low, and hands a filtered copy of that level to the rest of the chip when the reset is released. It runs on the free-running internal oscillator clock, which keeps toggling during reset. The pad bits first pass through a two-flop synchroniser. While the synchronised external reset level is low, every clock edge pushes the synchronised pad bits into a five-entry history per bit.

On the first clock edge at which the reset level is seen high after being low, the block takes a vote over the three oldest entries of each history. A result bit is 1 only when all three of those entries are 1. The most recent samples do not take part, so a pad that moves in the last few cycles before release does not disturb the captured value. The result and a valid flag are registered at that edge. Both hold while reset stays high, clear when reset goes low again, and clear on power-on reset.

The power-on reset also zeroes the synchroniser and the history. If reset is released very soon after power-on, the history has not filled and the affected bits read 0.

Top module: `bootmode_capture`

## Requirements
- R1: Let E be the capture edge. Output bit i (bit 0 is the lowest pad bit) is 1 only if raw pad bit i was 1 at each of the rising edges E-5, E-6 and E-7. The two-flop synchroniser adds two edges, so these three edges hold the three oldest of the five history samples.
- R2: A pad value that is held constant from edge E-7 up to and including edge E is captured exactly.
- R3: Pad changes that are first sampled at edges E-4 through E have no effect on the captured value.
- R4: If the pad value changes from A to B between edges E-7 and E-5, each captured bit is the AND of the corresponding bits of A and B.
- R5: The capture edge is the first rising edge at which `rst_lvl` is 1 after a cycle in which it was 0, or after power-on reset. `boot_mode` and `boot_valid` (1) appear after that edge.
- R6: While `rst_lvl` stays 1 after a capture, `boot_mode` and `boot_valid` do not change, whatever the pads do.
- R7: Each rising edge at which `rst_lvl` is 0 clears `boot_valid` and `boot_mode` to 0 for the next cycle. `boot_mode` is 0 whenever `boot_valid` is 0.
- R8: `por` is a synchronous, active-high reset. It clears the outputs, the synchroniser and the history. A release fewer than seven edges after `por` falls therefore yields 0 bits. A release with `rst_lvl` already high when `por` falls captures 0 with `boot_valid` = 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_osc | input | 1 | Free-running internal oscillator clock |
| por | input | 1 | Power-on reset, synchronous, active high |
| rst_lvl | input | 1 | Synchronised external reset level (0 = in reset) |
| pad_in | input | W (3) | Raw boot-mode pad bits, lowest pad in bit 0 |
| boot_mode | output | W (3) | Captured, filtered boot mode |
| boot_valid | output | 1 | Captured value present |

## Verification
The hardest situation to reach from the ports is a pad change that lands inside the three-sample voting window, where some old samples hold one value and others hold another. The vector table reaches it by holding value A for a long time, switching to B a chosen number of edges before the release, and sweeping that lead across the window boundaries. The sweep covers 1, 2, 4, 5, 6, 7 and 8 edges, so the bench observes the cases where the change is ignored, where it is ANDed, and where it is taken whole. Early release after power-on, and power-on reset during a held capture, are driven as directed cases.

// File: rtl/bmc_pkg.sv
package bmc_pkg;
  // Phase of the capture controller
  typedef enum logic [0:0] {
    PH_SAMPLE = 1'b0,  // reset low (or just after power-on): history runs
    PH_HELD   = 1'b1   // capture taken, result held while reset high
  } phase_t;

  localparam int unsigned SYNC_STAGES = 2;
endpackage

// File: rtl/bmc_sync.sv
module bmc_sync #(
  parameter int unsigned W      = 3,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) stg[0] <= '0;
    else     stg[0] <= d;
  end

  generate
    for (genvar s = 1; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) stg[s] <= '0;
        else     stg[s] <= stg[s-1];
      end
    end
  endgenerate

  assign q = stg[STAGES-1];
endmodule

// File: rtl/bmc_history.sv
module bmc_history #(
  parameter int unsigned W = 3,
  parameter int unsigned D = 5
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           en,
  input  logic [W-1:0]   din,
  output logic [W*D-1:0] hist_flat  // bit b*D+0 newest, b*D+D-1 oldest
);
  generate
    for (genvar b = 0; b < W; b++) begin : g_bit
      logic [D-1:0] sh;
      always_ff @(posedge clk) begin
        if (rst)     sh <= '0;
        else if (en) sh <= {sh[D-2:0], din[b]};
      end
      assign hist_flat[b*D +: D] = sh;
    end
  endgenerate
endmodule

// File: rtl/bmc_vote.sv
module bmc_vote #(
  parameter int unsigned W = 3,
  parameter int unsigned D = 5,
  parameter int unsigned V = 3
) (
  input  logic [W*D-1:0] hist_flat,
  output logic [W-1:0]   vote
);
  localparam int unsigned LOW = D - V;  // index of youngest voting entry

  generate
    for (genvar b = 0; b < W; b++) begin : g_bit
      assign vote[b] = &hist_flat[b*D + LOW +: V];
    end
  endgenerate
endmodule

// File: rtl/bootmode_capture.sv
module bootmode_capture #(
  parameter int unsigned W = 3,
  parameter int unsigned D = 5,
  parameter int unsigned V = 3
) (
  input  logic         clk_osc,
  input  logic         por,
  input  logic         rst_lvl,
  input  logic [W-1:0] pad_in,
  output logic [W-1:0] boot_mode,
  output logic         boot_valid
);
  import bmc_pkg::*;

  phase_t         ph;
  logic [W-1:0]   pad_s;
  logic [W*D-1:0] hist_flat;
  logic [W-1:0]   vote;

  bmc_sync #(.W(W), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk_osc),
    .rst (por),
    .d   (pad_in),
    .q   (pad_s)
  );

  bmc_history #(.W(W), .D(D)) u_hist (
    .clk       (clk_osc),
    .rst       (por),
    .en        (!rst_lvl),
    .din       (pad_s),
    .hist_flat (hist_flat)
  );

  bmc_vote #(.W(W), .D(D), .V(V)) u_vote (
    .hist_flat (hist_flat),
    .vote      (vote)
  );

  always_ff @(posedge clk_osc) begin
    if (por) begin
      ph         <= PH_SAMPLE;
      boot_mode  <= '0;
      boot_valid <= 1'b0;
    end else begin
      case (ph)
        PH_SAMPLE: begin
          if (rst_lvl) begin
            boot_mode  <= vote;
            boot_valid <= 1'b1;
            ph         <= PH_HELD;
          end
        end
        PH_HELD: begin
          if (!rst_lvl) begin
            boot_mode  <= '0;
            boot_valid <= 1'b0;
            ph         <= PH_SAMPLE;
          end
        end
        default: ph <= PH_SAMPLE;
      endcase
    end
  end
endmodule

// File: rtl/bootmode_capture_chk.sv
module bootmode_capture_chk #(
  parameter int unsigned W = 3,
  parameter int unsigned D = 5,
  parameter int unsigned V = 3
) (
  input logic           clk_osc,
  input logic           por,
  input logic           rst_lvl,
  input logic [W-1:0]   boot_mode,
  input logic           boot_valid,
  input logic [W*D-1:0] hist_flat
);
  p_valid_rise_r5: assert property (@(posedge clk_osc) disable iff (por)
    $rose(boot_valid) |-> $past(rst_lvl));

  p_clear_r7: assert property (@(posedge clk_osc) disable iff (por)
    !rst_lvl |=> (!boot_valid && boot_mode == '0));

  p_idle_zero_r7: assert property (@(posedge clk_osc) disable iff (por)
    !boot_valid |-> boot_mode == '0);

  p_hold_r6: assert property (@(posedge clk_osc) disable iff (por)
    (boot_valid && rst_lvl) |=> ($stable(boot_mode) && boot_valid));

  p_por_r8: assert property (@(posedge clk_osc)
    por |=> (!boot_valid && boot_mode == '0));

  generate
    for (genvar b = 0; b < W; b++) begin : g_vote
      p_vote_r1: assert property (@(posedge clk_osc) disable iff (por)
        $rose(boot_valid) |-> boot_mode[b] == (&$past(hist_flat[b*D + (D-V) +: V])));
    end
  endgenerate
endmodule

bind bootmode_capture bootmode_capture_chk #(.W(W), .D(D), .V(V)) u_chk (
  .clk_osc    (clk_osc),
  .por        (por),
  .rst_lvl    (rst_lvl),
  .boot_mode  (boot_mode),
  .boot_valid (boot_valid),
  .hist_flat  (hist_flat)
);

// File: tb/sim_bootmode_capture.sv
`timescale 1ns/1ps
module sim_bootmode_capture;
  localparam int W = 3;
  localparam realtime TCLK = 20.0;  // 50 MHz

  logic         clk_osc = 1'b0;
  logic         por = 1'b1;
  logic         rst_lvl = 1'b0;
  logic [W-1:0] pad_in = '1;
  logic [W-1:0] boot_mode;
  logic         boot_valid;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(TCLK/2) clk_osc = ~clk_osc;

  bootmode_capture #(.W(W), .D(5), .V(3)) u0 (
    .clk_osc (clk_osc), .por (por), .rst_lvl (rst_lvl),
    .pad_in (pad_in), .boot_mode (boot_mode), .boot_valid (boot_valid)
  );

  // fields: pad A, pad B, lead edges L (B set L edges before release), expected
  localparam int NV = 9;
  localparam logic [12:0] VEC [NV] = '{
    {3'd7, 3'd7, 4'd8, 3'd7},  // R2 steady all ones
    {3'd0, 3'd5, 4'd8, 3'd5},  // R2 change well before window
    {3'd7, 3'd2, 4'd8, 3'd2},  // R2
    {3'd5, 3'd0, 4'd7, 3'd0},  // R2 exactly at window start
    {3'd6, 3'd3, 4'd6, 3'd2},  // R4 AND of A and B
    {3'd7, 3'd5, 4'd5, 3'd5},  // R4
    {3'd6, 3'd1, 4'd4, 3'd6},  // R3 change too late
    {3'd3, 3'd4, 4'd2, 3'd3},  // R3
    {3'd1, 3'd6, 4'd1, 3'd1}   // R3
  };

  task automatic chk(input string tag, input logic [W:0] act, input logic [W:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic steps(input int n);
    for (int i = 0; i < n; i++) @(negedge clk_osc);
  endtask

  // drop reset, hold A, switch to B L edges before release, then release
  task automatic run_vec(input logic [W-1:0] a, input logic [W-1:0] b,
                         input int lead, input logic [W-1:0] exp, input int idx);
    @(negedge clk_osc);
    rst_lvl = 1'b0;
    pad_in  = a;
    steps(10);
    chk($sformatf("R7 vec%0d idle before release", idx), {boot_valid, boot_mode}, 4'h0);
    pad_in = b;
    steps(lead);
    chk($sformatf("R5 vec%0d no valid before edge", idx), {3'b0, boot_valid}, 4'h0);
    rst_lvl = 1'b1;
    steps(1);
    chk($sformatf("R1/R5 vec%0d capture", idx), {boot_valid, boot_mode}, {1'b1, exp});
  endtask

  initial begin
    #(TCLK * 200000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    // R8 reset state
    steps(3);
    chk("R8 reset state", {boot_valid, boot_mode}, 4'h0);

    // R8 early release: release two edges after por falls
    por = 1'b0;
    steps(2);
    rst_lvl = 1'b1;
    steps(1);
    chk("R8 early release gives zero", {boot_valid, boot_mode}, 4'h8);

    // R6 hold while reset high, pads moving
    for (int k = 0; k < 4; k++) begin
      pad_in = 3'(k * 3 + 1);
      steps(1);
      chk("R6 hold after capture", {boot_valid, boot_mode}, 4'h8);
    end

    // vector table: R1..R4
    for (int v = 0; v < NV; v++)
      run_vec(VEC[v][12:10], VEC[v][9:7], int'(VEC[v][6:3]), VEC[v][2:0], v);

    // R6 hold after a nonzero capture (last vector gave 1)
    pad_in = 3'd6;
    steps(3);
    chk("R6 hold nonzero", {boot_valid, boot_mode}, 4'h9);

    // R7 reassertion clears
    rst_lvl = 1'b0;
    steps(1);
    chk("R7 clear on reset low", {boot_valid, boot_mode}, 4'h0);

    // R8 por during a held capture, released with reset already high
    pad_in = 3'd7;
    steps(10);
    rst_lvl = 1'b1;
    steps(1);
    chk("R2 capture before por", {boot_valid, boot_mode}, 4'hF);
    por = 1'b1;
    steps(1);
    chk("R8 por clears held value", {boot_valid, boot_mode}, 4'h0);
    steps(2);
    por = 1'b0;
    steps(1);
    chk("R8 release with reset high captures zero", {boot_valid, boot_mode}, 4'h8);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule